// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns one decimal digit, arriving as a serial stream with its least significant bit first, into the excess-3 code for that digit. The excess-3 code is the digit plus three. Each qualified input bit produces the matching output bit in the same cycle. The output therefore depends on both the current state and the current input bit, as in any Mealy machine.

The sum is built one bit at a time. The constant 0011 is added, so one is added at bit positions 0 and 1 and nothing at positions 2 and 3. The carry and the bit position are held together in seven states. The state codes are chosen so that states with a shared successor or a shared output sit next to each other. After the fourth qualified bit the machine is back in its start state and can take the next digit at once.

Idle cycles, marked by a low qualifier, change nothing. A fourth bit of 1 that would carry out of the code cannot occur for a legal digit. It is treated as a code error. The same applies to reaching the one unassigned state code.

Top module: `xs3_serial_conv`

## Requirements
- R1: A synchronous reset, held high at a rising clock edge, returns the machine to its start state. This holds even in the middle of a digit and with the qualifier high. The error flag is low while reset is high and in the cycle after reset.
- R2: For a digit d from 0 to 12 sent as four qualified bits, least significant first, bit_out during the qualified cycle of bit i equals bit i of the 4-bit value d+3. This output is combinational.
- R3: After the fourth qualified bit the machine is in its start state, so a digit sent in the following qualified cycles converts with no gap and no reset.
- R4: While bit_vld is low, bit_out is 0 and the conversion state is held. Idle cycles inside a digit or between digits do not change any later output bit.
- R5: When the fourth qualified bit of a digit is 1 and the carry into bit 3 is 1 (digits 13 to 15), bit_out is 0 in that cycle. The machine returns to its start state, and code_err is high for exactly the one cycle after that clock edge.
- R6: code_err is low in every cycle that does not follow an error edge as described in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when bit_in carries a digit bit this cycle |
| bit_in | input | 1 | Serial BCD bit, least significant bit first |
| bit_out | output | 1 | Serial excess-3 bit; 0 while bit_vld is low |
| code_err | output | 1 | One-cycle pulse after an impossible fourth bit |

## Verification
The assertions assume that bit_vld and bit_in are stable around the clock edge. They also assume that digits are framed only by counting qualified bits, because the block has no start marker.

The stimulus changes inputs only on the falling edge. It sends every digit value, including the three that overflow. It places idle cycles both between digits and inside a digit, and it resets once partway through a digit. The unassigned state code cannot be reached from the ports, so only an assertion covers it.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  localparam int ST_W = 3;
  localparam logic [ST_W-1:0] S0 = 3'b000;
  localparam logic [ST_W-1:0] S1 = 3'b100;
  localparam logic [ST_W-1:0] S2 = 3'b101;
  localparam logic [ST_W-1:0] S3 = 3'b111;
  localparam logic [ST_W-1:0] S4 = 3'b110;
  localparam logic [ST_W-1:0] S5 = 3'b011;
  localparam logic [ST_W-1:0] S6 = 3'b010;
  localparam logic [ST_W-1:0] S_HOLE = 3'b001;

  // successor state: carry and bit position folded together
  function automatic logic [ST_W-1:0] step_next(input logic [ST_W-1:0] s, input logic x);
    case (s)
      S0:      return x ? S2 : S1;
      S1:      return x ? S4 : S3;
      S2:      return S4;
      S3:      return S5;
      S4:      return x ? S6 : S5;
      S5:      return S0;
      S6:      return S0;
      default: return S0;
    endcase
  endfunction

  // sum bit of input bit, constant bit and held carry
  function automatic logic step_out(input logic [ST_W-1:0] s, input logic x);
    case (s)
      S0, S1, S4, S6: return ~x;
      S2, S3, S5:     return x;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic step_bad(input logic [ST_W-1:0] s, input logic x);
    return (s == S6 && x) || (s == S_HOLE);
  endfunction
endpackage

// File: rtl/xs3_step.sv
module xs3_step
  import xs3_pkg::*;
(
  input  logic [ST_W-1:0] st,
  input  logic            vld,
  input  logic            x,
  output logic [ST_W-1:0] nxt,
  output logic            z,
  output logic            bad
);
  always_comb begin
    bad = vld & step_bad(st, x);
    nxt = step_bad(st, x) ? S0 : step_next(st, x);
    z   = vld & ~step_bad(st, x) & step_out(st, x);
  end
endmodule

// File: rtl/xs3_state_reg.sv
module xs3_state_reg
  import xs3_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [ST_W-1:0] nxt,
  input  logic            bad,
  output logic [ST_W-1:0] st,
  output logic            err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S0;
      err <= 1'b0;
    end else begin
      err <= bad;
      if (vld) st <= nxt;
    end
  end

  a_r4_hold_state: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(st));
  a_r3_wrap_start: assert property (@(posedge clk) disable iff (rst)
    (vld && (st == S5 || st == S6)) |=> (st == S0));
  a_r5_err_start: assert property (@(posedge clk) disable iff (rst)
    err |-> (st == S0));
  a_r3_no_hole: assert property (@(posedge clk) disable iff (rst)
    st != S_HOLE);
endmodule

// File: rtl/xs3_serial_conv.sv
module xs3_serial_conv
  import xs3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic bit_out,
  output logic code_err
);
  logic [ST_W-1:0] cur_st;
  logic [ST_W-1:0] nxt_st;
  logic            bad_evt;

  xs3_step u_step (
    .st  (cur_st),
    .vld (bit_vld),
    .x   (bit_in),
    .nxt (nxt_st),
    .z   (bit_out),
    .bad (bad_evt)
  );

  xs3_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .vld (bit_vld),
    .nxt (nxt_st),
    .bad (bad_evt),
    .st  (cur_st),
    .err (code_err)
  );

  a_r4_quiet_out: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !bit_out);
  a_r5_one_shot: assert property (@(posedge clk) disable iff (rst)
    code_err |=> !code_err);
  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    code_err |-> $past(bad_evt));
  a_r5_err_follows: assert property (@(posedge clk) disable iff (rst)
    bad_evt |=> code_err);
endmodule

// File: tb/sim_xs3_serial_conv.sv
module sim_xs3_serial_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic bit_out;
  logic code_err;
  int checks = 0;
  int errors = 0;
  logic exp_err = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  xs3_serial_conv u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_out(bit_out), .code_err(code_err)
  );

  // {digit, expected excess-3 bits, expected error, idle cycles after}
  localparam logic [10:0] VEC [16] = '{
    {4'd0,  4'd3,  1'b0, 2'd0}, {4'd9,  4'd12, 1'b0, 2'd1},
    {4'd5,  4'd8,  1'b0, 2'd0}, {4'd13, 4'd0,  1'b1, 2'd0},
    {4'd1,  4'd4,  1'b0, 2'd2}, {4'd12, 4'd15, 1'b0, 2'd0},
    {4'd7,  4'd10, 1'b0, 2'd3}, {4'd14, 4'd1,  1'b1, 2'd1},
    {4'd2,  4'd5,  1'b0, 2'd0}, {4'd11, 4'd14, 1'b0, 2'd0},
    {4'd4,  4'd7,  1'b0, 2'd1}, {4'd15, 4'd2,  1'b1, 2'd0},
    {4'd3,  4'd6,  1'b0, 2'd0}, {4'd10, 4'd13, 1'b0, 2'd2},
    {4'd6,  4'd9,  1'b0, 2'd0}, {4'd8,  4'd11, 1'b0, 2'd0}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: check the flag, drive, check z, pass the rising edge
  task automatic cyc(input logic v, input logic x, input logic expz, input logic bad_now,
                     input string tag);
    chk(code_err, exp_err, exp_err ? "R5 error pulse" : "R6 error low");
    bit_vld = v;
    bit_in  = x;
    #1;
    chk(bit_out, expz, tag);
    @(posedge clk);
    exp_err = bad_now;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4 idle output zero");
  endtask

  task automatic digit(input logic [3:0] d, input logic [3:0] e, input logic er,
                       input int gap_at, input int gap_len);
    for (int i = 0; i < 4; i++) begin
      if (i == gap_at) idle(gap_len);
      cyc(1'b1, d[i], e[i], (i == 3) && er, er ? "R5 overflow digit bit" : "R2 R3 digit bit");
    end
  endtask

  initial begin
    @(negedge clk);
    chk(code_err, 1'b0, "R1 error low in reset");
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(code_err, 1'b0, "R1 error low after reset");
    bit_vld = 1'b0;
    #1;
    chk(bit_out, 1'b0, "R4 output zero when idle");
    @(negedge clk);

    for (int j = 0; j < 16; j++) begin
      digit(VEC[j][10:7], VEC[j][6:3], VEC[j][2], 9, 0);
      idle(int'(VEC[j][1:0]));
    end

    // R4: idle cycles inside a digit
    digit(4'd6, 4'd9, 1'b0, 2, 3);
    digit(4'd9, 4'd12, 1'b0, 1, 2);

    // R1: reset partway through a digit, qualifier high
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R1 partial digit bit");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1 partial digit bit");
    rst = 1'b1;
    bit_vld = 1'b1;
    bit_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(code_err, 1'b0, "R1 error low after reset");
    digit(4'd2, 4'd5, 1'b0, 9, 0);

    // R5 then R3: overflow digit followed at once by a legal one
    digit(4'd13, 4'd0, 1'b1, 9, 0);
    digit(4'd0, 4'd3, 1'b0, 9, 0);
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule